// File: doc/BRIEF.md
# PC-Relative Jump Target Unit

This unit sits in the execute path of a small 16-bit-instruction processor. Each accepted instruction word is examined for an unconditional PC-relative jump, which comes in two flavours: a normal jump and a delayed jump. For a jump, the unit computes the 24-bit destination from the current PC and a signed halfword displacement. It also reports how many cycles the jump costs.

A separate immediate-extension prefix, decoded elsewhere, is announced to the unit by a strobe carrying a 13-bit immediate. The unit holds that immediate as pending until the next accepted instruction consumes it. When the consuming instruction is a jump, the short 10-bit displacement is widened to a full 24-bit displacement.

For a delayed jump, the unit flags that the following instruction is a slot instruction. It holds an interrupt mask from the jump until that slot instruction has been accepted. All results are registered and appear in the cycle after the instruction is accepted.

Top module: `pcrel_jump_unit`

## Requirements
- R1: Bits 15:10 of the accepted word select the operation: 000100 is a normal jump, 000101 is a delayed jump (bit 10 is the delay bit), and any other value is not a jump (jump_o stays 0). Bits 9:0 are the signed displacement field.
- R2: With no prefix pending, the target is PC + 2 + (sign-extended 10-bit field shifted left by one), giving a reach of PC-1022 to PC+1024.
- R3: With a prefix pending, the displacement is the 24-bit value {imm13, field[9:0], 0}, with imm13 in bits 23:11 and bit 0 zero. The target is PC + 2 + that value; for example, prefix 0x0020 with field 0 gives PC + 2 + 0x10000.
- R4: Target arithmetic wraps modulo 2^24.
- R5: Results appear in the cycle after an accepted instruction and last one cycle. cycles_o is 3 for a normal jump, 2 for a delayed jump and 0 otherwise; target_o is 0 when there is no jump.
- R6: slot_o is 1 exactly with a delayed jump.
- R7: irq_mask_o rises with a delayed jump's result. It stays high across idle cycles and prefix strobes, and falls in the cycle after the next accepted instruction.
- R8: Any accepted instruction consumes the pending prefix. A non-jump instruction after a prefix produces no jump, and a later jump uses the short form.
- R9: A prefix strobe while a prefix is already pending pulses illegal_o for one cycle and discards the pending prefix, so the next jump uses the short form.
- R10: When pfx_stb_i and insn_valid_i are high in the same cycle, the prefix is taken and the instruction is ignored.
- R11: Synchronous active-high rst clears the pending prefix, the interrupt mask and all result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid_i | input | 1 | Instruction word accepted this cycle |
| insn_i | input | 16 | Instruction word |
| pc_i | input | 24 | Address of the instruction |
| pfx_stb_i | input | 1 | Extension prefix accepted this cycle |
| pfx_imm_i | input | 13 | Immediate carried by the prefix |
| jump_o | output | 1 | Jump taken |
| target_o | output | 24 | Jump destination |
| slot_o | output | 1 | Next instruction is a delay slot |
| irq_mask_o | output | 1 | Interrupts held off |
| cycles_o | output | 2 | Cycle cost of the instruction |
| illegal_o | output | 1 | Stacked prefix detected |

## Verification
The hardest conditions to reach from the ports are the ones where pending-prefix state interacts with ordering: two prefixes back to back, a prefix and an instruction in the same cycle, and a reset landing while a prefix or the mask is live. The bench drives these as short directed sequences. After each sequence it issues a plain jump whose short-form or long-form target shows whether the hidden prefix survived. The mask is checked across idle cycles and an interleaved prefix strobe before the slot instruction arrives.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;
    localparam int PC_W    = 24;
    localparam int INSN_W  = 16;
    localparam int FIELD_W = 10;
    localparam int IMM_W   = 13;
    localparam int CYC_W   = 2;
    localparam int OP_W    = INSN_W - FIELD_W;

    localparam logic [OP_W-1:0]  OP_JUMP   = 6'b000100;
    localparam logic [CYC_W-1:0] CYC_NORM  = 2'd3;
    localparam logic [CYC_W-1:0] CYC_DELAY = 2'd2;

    typedef struct packed {
        logic              pend;
        logic [IMM_W-1:0]  pend_imm;
        logic              jump;
        logic              slot;
        logic [PC_W-1:0]   target;
        logic [CYC_W-1:0]  cycles;
        logic              illegal;
        logic              mask;
    } unit_state_t;
endpackage

// File: rtl/pcrel_decode.sv
module pcrel_decode #(
    parameter int INSN_W  = 16,
    parameter int FIELD_W = 10,
    parameter logic [INSN_W-FIELD_W-1:0] OP_BASE = '0
) (
    input  logic [INSN_W-1:0]  insn_i,
    output logic               is_jump_o,
    output logic               is_delay_o,
    output logic [FIELD_W-1:0] field_o
);
    localparam int OP_W = INSN_W - FIELD_W;

    logic [OP_W-1:0] opcode;

    always_comb begin
        opcode     = insn_i[INSN_W-1:FIELD_W];
        field_o    = insn_i[FIELD_W-1:0];
        // The low opcode bit is the delay selector; the rest must match.
        is_jump_o  = (opcode[OP_W-1:1] == OP_BASE[OP_W-1:1]);
        is_delay_o = opcode[0];
    end
endmodule

// File: rtl/pcrel_disp.sv
module pcrel_disp #(
    parameter int PC_W    = 24,
    parameter int FIELD_W = 10,
    parameter int IMM_W   = 13
) (
    input  logic               ext_en_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic [PC_W-1:0]    disp_o
);
    localparam int SHORT_FILL = PC_W - FIELD_W - 1;
    localparam int EXT_W      = IMM_W + FIELD_W + 1;

    logic [PC_W-1:0]  short_disp;
    logic [EXT_W-1:0] ext_raw;
    logic [PC_W-1:0]  ext_disp;

    assign short_disp = {{SHORT_FILL{field_i[FIELD_W-1]}}, field_i, 1'b0};
    assign ext_raw    = {imm_i, field_i, 1'b0};

    generate
        if (EXT_W < PC_W) begin : g_ext_sext
            assign ext_disp = {{(PC_W-EXT_W){imm_i[IMM_W-1]}}, ext_raw};
        end else begin : g_ext_trunc
            assign ext_disp = ext_raw[PC_W-1:0];
        end
    endgenerate

    assign disp_o = ext_en_i ? ext_disp : short_disp;
endmodule

// File: rtl/pcrel_target.sv
module pcrel_target #(
    parameter int PC_W = 24
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] disp_i,
    output logic [PC_W-1:0] target_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(2);

    assign target_o = pc_i + STEP + disp_i;
endmodule

// File: rtl/pcrel_jump_unit.sv
module pcrel_jump_unit
    import pcrel_pkg::*;
#(
    parameter int P_PC_W    = PC_W,
    parameter int P_INSN_W  = INSN_W,
    parameter int P_FIELD_W = FIELD_W,
    parameter int P_IMM_W   = IMM_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 insn_valid_i,
    input  logic [P_INSN_W-1:0]  insn_i,
    input  logic [P_PC_W-1:0]    pc_i,
    input  logic                 pfx_stb_i,
    input  logic [P_IMM_W-1:0]   pfx_imm_i,
    output logic                 jump_o,
    output logic [P_PC_W-1:0]    target_o,
    output logic                 slot_o,
    output logic                 irq_mask_o,
    output logic [CYC_W-1:0]     cycles_o,
    output logic                 illegal_o
);
    unit_state_t st_d, st_q;

    logic                 dec_jump;
    logic                 dec_delay;
    logic [P_FIELD_W-1:0] dec_field;
    logic [P_PC_W-1:0]    disp;
    logic [P_PC_W-1:0]    tgt;

    pcrel_decode #(
        .INSN_W (P_INSN_W),
        .FIELD_W(P_FIELD_W),
        .OP_BASE(OP_JUMP)
    ) u_decode (
        .insn_i    (insn_i),
        .is_jump_o (dec_jump),
        .is_delay_o(dec_delay),
        .field_o   (dec_field)
    );

    pcrel_disp #(
        .PC_W   (P_PC_W),
        .FIELD_W(P_FIELD_W),
        .IMM_W  (P_IMM_W)
    ) u_disp (
        .ext_en_i(st_q.pend),
        .imm_i   (st_q.pend_imm),
        .field_i (dec_field),
        .disp_o  (disp)
    );

    pcrel_target #(
        .PC_W(P_PC_W)
    ) u_target (
        .pc_i    (pc_i),
        .disp_i  (disp),
        .target_o(tgt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.jump    = 1'b0;
        st_d.slot    = 1'b0;
        st_d.target  = '0;
        st_d.cycles  = '0;
        st_d.illegal = 1'b0;

        if (pfx_stb_i) begin
            // A prefix wins over a same-cycle instruction.
            if (st_q.pend) begin
                st_d.illegal  = 1'b1;
                st_d.pend     = 1'b0;
                st_d.pend_imm = '0;
            end else begin
                st_d.pend     = 1'b1;
                st_d.pend_imm = pfx_imm_i;
            end
        end else if (insn_valid_i) begin
            st_d.pend     = 1'b0;
            st_d.pend_imm = '0;
            if (dec_jump) begin
                st_d.jump   = 1'b1;
                st_d.slot   = dec_delay;
                st_d.target = tgt;
                st_d.cycles = dec_delay ? CYC_DELAY : CYC_NORM;
            end
            // Set by a delayed jump, released by the slot instruction.
            st_d.mask = dec_jump & dec_delay;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign jump_o     = st_q.jump;
    assign target_o   = st_q.target;
    assign slot_o     = st_q.slot;
    assign irq_mask_o = st_q.mask;
    assign cycles_o   = st_q.cycles;
    assign illegal_o  = st_q.illegal;
endmodule

// File: rtl/pcrel_jump_checker.sv
module pcrel_jump_checker (
    input logic       clk,
    input logic       rst,
    input logic       insn_valid_i,
    input logic       pfx_stb_i,
    input logic       jump_o,
    input logic       slot_o,
    input logic       irq_mask_o,
    input logic [1:0] cycles_o,
    input logic       illegal_o,
    input logic       pend
);
    // R5: cycle cost matches the jump kind
    a_r5_cycle_cost: assert property (@(posedge clk) disable iff (rst)
        jump_o |-> (cycles_o == 2'd3 || cycles_o == 2'd2));

    // R5: no result without an accepted instruction
    a_r5_needs_insn: assert property (@(posedge clk) disable iff (rst)
        (!insn_valid_i || pfx_stb_i) |=> !jump_o);

    // R6: slot flag only with a two-cycle jump
    a_r6_slot_is_delayed: assert property (@(posedge clk) disable iff (rst)
        slot_o |-> (jump_o && cycles_o == 2'd2));

    // R7: mask accompanies the slot flag
    a_r7_mask_with_slot: assert property (@(posedge clk) disable iff (rst)
        slot_o |-> irq_mask_o);

    // R7: mask held while no instruction is accepted
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (rst)
        (irq_mask_o && !(insn_valid_i && !pfx_stb_i)) |=> irq_mask_o);

    // R8: an accepted instruction leaves nothing pending
    a_r8_consume: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_i && !pfx_stb_i) |=> !pend);

    // R9: stacked prefix flagged and discarded
    a_r9_stacked: assert property (@(posedge clk) disable iff (rst)
        (pfx_stb_i && pend) |=> (illegal_o && !pend));

    // R9: illegal flag is a single-cycle pulse
    a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> !illegal_o);
endmodule

bind pcrel_jump_unit pcrel_jump_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .insn_valid_i(insn_valid_i),
    .pfx_stb_i   (pfx_stb_i),
    .jump_o      (jump_o),
    .slot_o      (slot_o),
    .irq_mask_o  (irq_mask_o),
    .cycles_o    (cycles_o),
    .illegal_o   (illegal_o),
    .pend        (st_q.pend)
);

// File: tb/pcrel_jump_unit_bench.sv
`timescale 1ns/1ps
module pcrel_jump_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid_i = 1'b0;
    logic [15:0] insn_i = '0;
    logic [23:0] pc_i = '0;
    logic        pfx_stb_i = 1'b0;
    logic [12:0] pfx_imm_i = '0;
    logic        jump_o;
    logic [23:0] target_o;
    logic        slot_o;
    logic        irq_mask_o;
    logic [1:0]  cycles_o;
    logic        illegal_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pcrel_jump_unit u_pcrel_jump_unit (
        .clk         (clk),
        .rst         (rst),
        .insn_valid_i(insn_valid_i),
        .insn_i      (insn_i),
        .pc_i        (pc_i),
        .pfx_stb_i   (pfx_stb_i),
        .pfx_imm_i   (pfx_imm_i),
        .jump_o      (jump_o),
        .target_o    (target_o),
        .slot_o      (slot_o),
        .irq_mask_o  (irq_mask_o),
        .cycles_o    (cycles_o),
        .illegal_o   (illegal_o)
    );

    // {pfx_en, imm13, insn, pc, exp_jump, exp_target, exp_cycles, exp_slot}
    localparam int NV = 10;
    localparam logic [81:0] VEC [NV] = '{
        {1'b0, 13'h0000, 16'h1000, 24'h000100, 1'b1, 24'h000102, 2'd3, 1'b0}, // R2 zero field
        {1'b0, 13'h0000, 16'h11FF, 24'h000100, 1'b1, 24'h000500, 2'd3, 1'b0}, // R2 max forward
        {1'b0, 13'h0000, 16'h1200, 24'h001000, 1'b1, 24'h000C02, 2'd3, 1'b0}, // R2 max backward
        {1'b0, 13'h0000, 16'h1405, 24'h000200, 1'b1, 24'h00020C, 2'd2, 1'b1}, // R6 delayed
        {1'b1, 13'h0020, 16'h1000, 24'h001000, 1'b1, 24'h011002, 2'd3, 1'b0}, // R3 example
        {1'b1, 13'h1FFF, 16'h13FF, 24'h000100, 1'b1, 24'h000100, 2'd3, 1'b0}, // R3 negative
        {1'b1, 13'h0FFF, 16'h17FF, 24'h000000, 1'b1, 24'h800000, 2'd2, 1'b1}, // R3 delayed long
        {1'b0, 13'h0000, 16'h1000, 24'hFFFFFE, 1'b1, 24'h000000, 2'd3, 1'b0}, // R4 wrap short
        {1'b1, 13'h1000, 16'h1000, 24'h800000, 1'b1, 24'h000002, 2'd3, 1'b0}, // R4 wrap long
        {1'b0, 13'h0000, 16'h1800, 24'h000100, 1'b0, 24'h000000, 2'd0, 1'b0}  // R1 non-jump
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks enter and leave at a falling edge.
    task automatic send_pfx(input logic [12:0] imm);
        pfx_stb_i = 1'b1;
        pfx_imm_i = imm;
        @(negedge clk);
        pfx_stb_i = 1'b0;
    endtask

    task automatic send_insn(input logic [15:0] w, input logic [23:0] pc);
        insn_valid_i = 1'b1;
        insn_i = w;
        pc_i = pc;
        @(negedge clk);
        insn_valid_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 jump", jump_o, 0);
        check("R11 mask", irq_mask_o, 0);
        check("R11 illegal", illegal_o, 0);
        check("R11 cycles", cycles_o, 0);
        check("R11 target", target_o, 0);

        for (int i = 0; i < NV; i++) begin
            logic [81:0] e;
            e = VEC[i];
            if (e[81]) send_pfx(e[80:68]);
            send_insn(e[67:52], e[51:28]);
            check("R1 jump", jump_o, e[27]);
            check("R2/R3/R4 target", target_o, e[26:3]);
            check("R5 cycles", cycles_o, e[2:1]);
            check("R6 slot", slot_o, e[0]);
            check("R7 mask set", irq_mask_o, e[0]);
            send_insn(16'h0000, 24'h000010);
            check("R5 pulse", jump_o, 0);
            check("R7 mask clear", irq_mask_o, 0);
        end

        // R7 mask held across idle and prefix
        send_insn(16'h1401, 24'h000300);
        check("R7 mask rise", irq_mask_o, 1);
        repeat (3) @(negedge clk);
        check("R7 mask idle", irq_mask_o, 1);
        send_pfx(13'h0005);
        check("R7 mask after prefix", irq_mask_o, 1);
        send_insn(16'h0000, 24'h000302);
        check("R7 mask fall", irq_mask_o, 0);
        check("R8 nonjump after prefix", jump_o, 0);
        send_insn(16'h1000, 24'h000100);
        check("R8 consumed short", target_o, 24'h000102);

        // R9 stacked prefix
        send_pfx(13'h0020);
        check("R9 first prefix", illegal_o, 0);
        send_pfx(13'h0020);
        check("R9 illegal", illegal_o, 1);
        @(negedge clk);
        check("R9 pulse", illegal_o, 0);
        send_insn(16'h1000, 24'h001000);
        check("R9 short after discard", target_o, 24'h001002);

        // R10 simultaneous prefix and instruction
        pfx_stb_i = 1'b1;
        pfx_imm_i = 13'h0020;
        insn_valid_i = 1'b1;
        insn_i = 16'h1000;
        pc_i = 24'h001000;
        @(negedge clk);
        pfx_stb_i = 1'b0;
        insn_valid_i = 1'b0;
        check("R10 insn ignored", jump_o, 0);
        send_insn(16'h1000, 24'h001000);
        check("R10 prefix taken", target_o, 24'h011002);

        // R11 reset clears pending prefix
        send_pfx(13'h0020);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        send_insn(16'h1000, 24'h001000);
        check("R11 pending cleared", target_o, 24'h001002);

        // R11 reset clears mask
        send_insn(16'h1400, 24'h000100);
        check("R11 mask before reset", irq_mask_o, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 mask reset", irq_mask_o, 0);
        check("R11 jump reset", jump_o, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule